// File: doc/BRIEF.md
# Byte-Handshake Host Command and Readout Port

This block sits between a host computer's 8-bit parallel I/O card and the acquisition side of a sampling system. The host writes command bytes on one byte lane, each qualified by a strobe. The block answers each strobe with an acknowledge. Recognised commands become single-cycle strobes toward the sampling sequencer: one clears the sample memory and one starts a sampling run. A third command starts a readout of the whole sample memory.

During a readout the block walks the memory from address 0 to the last address. It fetches each sixteen-bit word through a synchronous read port with a latency of one cycle. Each word goes out on a separate 8-bit output lane as two bytes, the low byte first and then the high byte. Every byte is held with a valid flag until the host acknowledges it, and the next byte is only offered after the host has released that acknowledge. A done flag reports that the final high byte was taken. Every input coming from the host passes through a two-flip-flop synchroniser before it is used.

Top module: `host_byte_port`

## Requirements
- R1: Reset is synchronous and active high. While in reset and directly after it, `cmd_ack`, `dout_valid`, `xfer_busy`, `xfer_done`, `mem_clr_stb` and `smp_go_stb` are all 0.
- R2: A command byte of 0x01 that is strobed in produces exactly one `mem_clr_stb` pulse, one clock cycle wide.
- R3: A command byte of 0x02 that is strobed in produces exactly one `smp_go_stb` pulse, one clock cycle wide.
- R4: Any command byte other than 0x01, 0x02 and 0x03 is acknowledged but has no other effect: no strobe pulse, no readout and no byte on `dout`.
- R5: `cmd_ack` rises after `cmd_stb` rises. It stays high for as long as `cmd_stb` stays high, and it falls within a few cycles after `cmd_stb` falls.
- R6: A command byte of 0x03 received while idle starts a readout. For each address a, from 0 up to 2^ADDR_W-1 in order, `dout` first carries bits 7:0 and then bits 15:8 of the word at address a. `mem_addr` equals a while either byte is offered.
- R7: Once `dout_valid` is raised, it stays high and `dout` stays unchanged until the synchronised `host_ack` is seen high. `dout_valid` then falls.
- R8: After a byte has been acknowledged, `dout_valid` stays low for as long as `host_ack` stays high.
- R9: `xfer_done` rises when the high byte of the last word has been acknowledged. `xfer_busy` falls after `host_ack` is released. `xfer_done` is cleared by a new readout start or by command 0x01.
- R10: A 0x03 command that arrives during an active readout is acknowledged but ignored. The readout carries on without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Host command byte |
| cmd_stb | input | 1 | Host command strobe (asynchronous) |
| cmd_ack | output | 1 | Command acknowledge to the host |
| dout | output | 8 | Readout byte to the host |
| dout_valid | output | 1 | Readout byte valid |
| host_ack | input | 1 | Host acknowledge of a readout byte (asynchronous) |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| mem_clr_stb | output | 1 | One-cycle request to clear memory |
| smp_go_stb | output | 1 | One-cycle request to start sampling |
| xfer_busy | output | 1 | Readout in progress |
| xfer_done | output | 1 | Readout completed |

## Verification
A wrong byte-phase or index state appears on the very next offered byte. It shows as a swapped low/high byte, a repeated or skipped word, or a `mem_addr` that does not match the word count. A fault in the final-word detection shows after the last acknowledge: the readout either stops early with `xfer_done` set, or keeps running past the end with `xfer_busy` still high. A wrong decoder state shows within a handful of cycles of the command strobe, as a missing, extra or doubled strobe pulse or as a `cmd_ack` that does not follow `cmd_stb`.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [BYTE_W-1:0] OP_CLEAR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_SAMPLE = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;

    typedef enum logic [2:0] {
        X_IDLE,
        X_ADDR,
        X_FETCH,
        X_SHOW,
        X_WAIT
    } xfer_state_t;

    typedef struct packed {
        logic clr;
        logic smp;
        logic go;
    } cmd_pulse_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic upper);
        return upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbp_cmd.sv
module hbp_cmd
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_s,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              busy,
    output logic              cmd_ack,
    output cmd_pulse_t        pulse
);
    logic stb_d;
    logic rise;

    assign rise = stb_s & ~stb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_d   <= 1'b0;
            cmd_ack <= 1'b0;
            pulse   <= '0;
        end else begin
            stb_d     <= stb_s;
            cmd_ack   <= rise | (cmd_ack & stb_s);
            pulse.clr <= rise && (cmd_byte == OP_CLEAR);
            pulse.smp <= rise && (cmd_byte == OP_SAMPLE);
            pulse.go  <= rise && (cmd_byte == OP_READ) && !busy;
        end
    end

    p_clr_single_r2: assert property (@(posedge clk) disable iff (rst)
        pulse.clr |=> !pulse.clr);
    p_smp_single_r3: assert property (@(posedge clk) disable iff (rst)
        pulse.smp |=> !pulse.smp);
    p_one_action_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse));
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_ack && stb_s |=> cmd_ack);
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !stb_s |=> !cmd_ack);
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pulse.go);
endmodule

// File: rtl/hbp_xfer.sv
module hbp_xfer
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              clr,
    input  logic              ack_s,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_valid,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

    xfer_state_t       st;
    logic [ADDR_W-1:0] idx;
    logic [WORD_W-1:0] word_q;
    logic              hi_sel;
    logic              last;

    assign last     = (idx == LAST_IDX);
    assign mem_addr = idx;
    assign busy     = (st != X_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= X_IDLE;
            idx        <= '0;
            word_q     <= '0;
            hi_sel     <= 1'b0;
            dout       <= '0;
            dout_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            if (clr) done <= 1'b0;
            unique case (st)
                X_IDLE: if (go) begin
                    idx  <= '0;
                    done <= 1'b0;
                    st   <= X_ADDR;
                end
                X_ADDR: st <= X_FETCH;
                X_FETCH: begin
                    word_q     <= mem_rdata;
                    dout       <= pick_byte(mem_rdata, 1'b0);
                    dout_valid <= 1'b1;
                    hi_sel     <= 1'b0;
                    st         <= X_SHOW;
                end
                X_SHOW: if (ack_s) begin
                    dout_valid <= 1'b0;
                    if (hi_sel && last) done <= 1'b1;
                    st <= X_WAIT;
                end
                X_WAIT: if (!ack_s) begin
                    if (!hi_sel) begin
                        dout       <= pick_byte(word_q, 1'b1);
                        dout_valid <= 1'b1;
                        hi_sel     <= 1'b1;
                        st         <= X_SHOW;
                    end else if (last) begin
                        st <= X_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= X_ADDR;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        dout_valid && !ack_s |=> dout_valid);
    p_dout_stable_r7: assert property (@(posedge clk) disable iff (rst)
        dout_valid && !ack_s |=> $stable(dout));
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        dout_valid && ack_s |=> !dout_valid);
    p_no_early_byte_r8: assert property (@(posedge clk) disable iff (rst)
        !dout_valid && ack_s |=> !dout_valid);
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !dout_valid);
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> $stable(mem_addr));
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbp_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cmd_byte,
    input  logic              cmd_stb,
    output logic              cmd_ack,
    output logic [7:0]        dout,
    output logic              dout_valid,
    input  logic              host_ack,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              mem_clr_stb,
    output logic              smp_go_stb,
    output logic              xfer_busy,
    output logic              xfer_done
);
    logic [1:0] hs_raw;
    logic [1:0] hs_s;
    cmd_pulse_t pulse;

    assign hs_raw = {host_ack, cmd_stb};

    hbp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_raw),
        .q   (hs_s)
    );

    hbp_cmd u_cmd (
        .clk      (clk),
        .rst      (rst),
        .stb_s    (hs_s[0]),
        .cmd_byte (cmd_byte),
        .busy     (xfer_busy),
        .cmd_ack  (cmd_ack),
        .pulse    (pulse)
    );

    hbp_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .go         (pulse.go),
        .clr        (pulse.clr),
        .ack_s      (hs_s[1]),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .dout       (dout),
        .dout_valid (dout_valid),
        .busy       (xfer_busy),
        .done       (xfer_done)
    );

    assign mem_clr_stb = pulse.clr;
    assign smp_go_stb  = pulse.smp;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !cmd_ack && !dout_valid && !xfer_busy && !xfer_done && !mem_clr_stb && !smp_go_stb);
endmodule

// File: tb/sim_host_byte_port.sv
module sim_host_byte_port;
    localparam int AW    = 3;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cmd_byte = 8'h00;
    logic          cmd_stb = 1'b0;
    logic          cmd_ack;
    logic [7:0]    dout;
    logic          dout_valid;
    logic          host_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = 16'h0000;
    logic          mem_clr_stb;
    logic          smp_go_stb;
    logic          xfer_busy;
    logic          xfer_done;

    int n_chk = 0;
    int n_bad = 0;
    int n_clr = 0;
    int n_smp = 0;
    logic [15:0] seed = 16'h0000;

    always #2.5 clk = ~clk;

    host_byte_port #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb), .cmd_ack(cmd_ack),
        .dout(dout), .dout_valid(dout_valid), .host_ack(host_ack), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_clr_stb(mem_clr_stb), .smp_go_stb(smp_go_stb),
        .xfer_busy(xfer_busy), .xfer_done(xfer_done)
    );

    function automatic logic [15:0] pat(input int a, input logic [15:0] s);
        return 16'((a * 16'h1357) ^ 16'hC0DE ^ s);
    endfunction

    always @(posedge clk) mem_rdata <= pat(int'(mem_addr), seed);

    always @(negedge clk) begin
        if (mem_clr_stb) n_clr++;
        if (smp_go_stb)  n_smp++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic send_cmd(input logic [7:0] code);
        int t;
        @(negedge clk);
        cmd_byte = code;
        cmd_stb  = 1'b1;
        t = 0;
        while (!cmd_ack && t < 20) begin @(negedge clk); t++; end
        chk(cmd_ack == 1'b1, "R5 ack rise", int'(cmd_ack), 1);
        repeat (3) @(negedge clk);
        chk(cmd_ack == 1'b1, "R5 ack held", int'(cmd_ack), 1);
        cmd_stb = 1'b0;
        t = 0;
        while (cmd_ack && t < 20) begin @(negedge clk); t++; end
        chk(cmd_ack == 1'b0, "R5 ack fall", int'(cmd_ack), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_byte(input int dly, input logic [7:0] exp_b, input int exp_a, input string tag);
        int t;
        logic [7:0] first;
        t = 0;
        while (!dout_valid && t < 40) begin @(negedge clk); t++; end
        chk(dout_valid == 1'b1, "R6 byte offered", int'(dout_valid), 1);
        first = dout;
        chk(dout == exp_b, tag, int'(dout), int'(exp_b));
        chk(int'(mem_addr) == exp_a, "R6 address", int'(mem_addr), exp_a);
        repeat (dly) @(negedge clk);
        chk(dout_valid == 1'b1 && dout == first, "R7 hold before ack", int'(dout), int'(first));
        host_ack = 1'b1;
        t = 0;
        while (dout_valid && t < 20) begin @(negedge clk); t++; end
        chk(dout_valid == 1'b0, "R7 valid drop", int'(dout_valid), 0);
        repeat (dly + 2) @(negedge clk);
        chk(dout_valid == 1'b0, "R8 no byte while ack high", int'(dout_valid), 0);
        host_ack = 1'b0;
    endtask

    task automatic read_all(input int dly);
        for (int w = 0; w < WORDS; w++) begin
            logic [15:0] e;
            e = pat(w, seed);
            read_byte(dly, e[7:0], w, "R6 low byte");
            if (w == WORDS - 1) chk(xfer_done == 1'b0, "R9 done not before last", int'(xfer_done), 0);
            read_byte(dly, e[15:8], w, "R6 high byte");
        end
    endtask

    task automatic end_of_read();
        repeat (8) @(negedge clk);
        chk(xfer_done == 1'b1, "R9 done set", int'(xfer_done), 1);
        chk(xfer_busy == 1'b0, "R9 busy clear", int'(xfer_busy), 0);
        chk(dout_valid == 1'b0, "R9 no extra byte", int'(dout_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!cmd_ack && !dout_valid && !xfer_busy && !xfer_done && !mem_clr_stb && !smp_go_stb,
            "R1 reset outputs", int'({cmd_ack, dout_valid, xfer_busy, xfer_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_ack && !dout_valid && !xfer_busy && !xfer_done,
            "R1 after reset", int'({cmd_ack, dout_valid, xfer_busy, xfer_done}), 0);

        // sweep every command code except the readout start
        for (int c = 0; c < 256; c++) begin
            int pc, ps;
            if (c == 3) continue;
            pc = n_clr;
            ps = n_smp;
            send_cmd(8'(c));
            if (c == 1) begin
                chk(n_clr == pc + 1, "R2 clear pulse count", n_clr - pc, 1);
                chk(n_smp == ps, "R2 no sample pulse", n_smp - ps, 0);
            end else if (c == 2) begin
                chk(n_smp == ps + 1, "R3 sample pulse count", n_smp - ps, 1);
                chk(n_clr == pc, "R3 no clear pulse", n_clr - pc, 0);
            end else begin
                chk(n_clr == pc && n_smp == ps, "R4 no strobe", (n_clr - pc) + (n_smp - ps), 0);
                chk(!xfer_busy && !dout_valid, "R4 no readout", int'({xfer_busy, dout_valid}), 0);
            end
        end

        // readout with quick host
        seed = 16'h0000;
        send_cmd(8'h03);
        chk(xfer_busy == 1'b1, "R6 readout started", int'(xfer_busy), 1);
        read_all(0);
        end_of_read();

        // command 0x01 clears done
        send_cmd(8'h01);
        chk(xfer_done == 1'b0, "R9 clear resets done", int'(xfer_done), 0);

        // slow host, new pattern
        seed = 16'h5A3C;
        send_cmd(8'h03);
        read_all(5);
        end_of_read();

        // new start clears done; duplicate start mid-readout ignored
        seed = 16'h9E17;
        send_cmd(8'h03);
        chk(xfer_done == 1'b0, "R9 start resets done", int'(xfer_done), 0);
        fork
            read_all(2);
            begin
                repeat (30) @(negedge clk);
                send_cmd(8'h03);
            end
        join
        end_of_read();
        repeat (10) @(negedge clk);
        chk(xfer_busy == 1'b0 && dout_valid == 1'b0, "R10 no restart",
            int'({xfer_busy, dout_valid}), 0);

        finish_run();
    end
endmodule